// File: doc/BRIEF.md
# Double-Buffered Channel Memory Manager

This block keeps two sets of sample memory for a processor that serves 256 channels. Each set is made of three 16-bit memories with 256 entries each. The three memories in a set hold different per-channel quantities: sample history, filter coefficients and working state. A common 8-bit index addresses all three, and a 2-bit field code picks one of them. One set belongs to even-numbered channels and the other to odd-numbered channels.

At any time the processing engine reads and writes one set, called the active set. The fill stream loads the other set from external memory. Each fill write carries a channel number, and the lowest bit of that number picks the target set. A write that lands on the active set is refused, and an overrun flag is raised.

At a frame boundary a swap request exchanges the two roles. The block accepts the swap only after the fill side has reported that it is finished and while the processing side is idle. Both sides run on one clock.

Top module: `pp_buf_mgr`

## Requirements
- R1: After reset, `bank_sel` is 0, `proc_rdata` is 0 and `fill_overrun` is 0. A `bank_sel` of 0 means the even set (channel bit 0 = 0) is active and the odd set is the fill target.
- R2: A fill write whose channel parity (`fill_chan[0]`) differs from `bank_sel` is stored in the memory named by `fill_field`, at entry `fill_addr`. After a swap it can be read back on the processing port.
- R3: A fill write whose channel parity equals `bank_sel` does not change the memory. `fill_overrun` is 1 in exactly the cycle after that write, and 0 in the cycle after any accepted write.
- R4: A processing read (`proc_en`=1, `proc_we`=0) puts the active set's word for `proc_field` and `proc_addr` on `proc_rdata` one cycle later. In every other cycle `proc_rdata` keeps its value.
- R5: A processing write (`proc_en`=1, `proc_we`=1) updates the active set's memory at `proc_field` and `proc_addr`. A later read returns the new value.
- R6: A swap is accepted when `swap_req` is 1, a fill has been reported finished, `proc_busy` is 0 and `proc_en` is 0. `bank_sel` then inverts at the next clock edge.
- R7: A `fill_done` pulse marks the fill as finished. An accepted swap clears that mark, unless `fill_done` is high in the same cycle; in that case the mark stays set.
- R8: A swap request made while no fill is marked finished, or while `proc_busy` or `proc_en` is 1, leaves `bank_sel` unchanged.
- R9: Field codes 0, 1 and 2 select three independent memories, so one address holds three distinct words. Field code 3 reads as 0, and writes with field code 3 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fill write strobe |
| fill_chan | input | 8 | Channel number of the fill word; bit 0 picks the set |
| fill_field | input | 2 | Memory within the set (0..2) |
| fill_addr | input | 8 | Entry index |
| fill_data | input | 16 | Fill write data |
| fill_done | input | 1 | Pulse: the target set has been fully loaded |
| proc_en | input | 1 | Processing access strobe |
| proc_we | input | 1 | Processing access is a write |
| proc_field | input | 2 | Memory within the active set |
| proc_addr | input | 8 | Entry index in the active set |
| proc_wdata | input | 16 | Processing write data |
| proc_busy | input | 1 | Engine is mid-frame; blocks a swap |
| swap_req | input | 1 | Frame-boundary swap request |
| proc_rdata | output | 16 | Registered read data from the active set |
| bank_sel | output | 1 | Parity of the active set |
| fill_overrun | output | 1 | One-cycle pulse after a refused fill write |

## Verification
The bench fills the odd set through a table of writes and reads every word back after a swap. A design that routed a channel to the wrong set, or mixed up the three fields, would return the wrong words here.

Swaps are tried without a finished fill and with the engine busy. A design that ignored either condition would invert `bank_sel` too early.

A refused fill aimed at a word already holding known data must leave that word unchanged and produce a single overrun pulse. A design that let the write through would corrupt live data, and one with a sticky or missing flag would fail the pulse check.

A swap is also issued in the same cycle as `fill_done`, followed by two more requests. A design that gave the clear priority would refuse the second swap, and one that never cleared the mark would accept the third.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
  typedef enum logic [1:0] {
    FLD_HIST  = 2'd0,
    FLD_COEF  = 2'd1,
    FLD_STATE = 2'd2,
    FLD_NONE  = 2'd3
  } field_e;

  // A fill word collides with live data when its channel parity names the active set.
  function automatic logic fill_collides(input logic chan_lsb, input logic active_set);
    return chan_lsb == active_set;
  endfunction

  // Frame swap gate: request, loaded target, and a quiet engine.
  function automatic logic swap_allowed(input logic req, input logic loaded,
                                        input logic busy, input logic access);
    return req && loaded && !busy && !access;
  endfunction
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int N_FIELDS = 3,
  parameter int FIELD_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FIELD_W-1:0] rd_field,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word [N_FIELDS];

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_field == FIELD_W'(g)) mem[wr_addr] <= wr_data;
    end
    assign word[g] = mem[rd_addr];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_FIELDS; i++) begin
      if (rd_field == FIELD_W'(i)) rd_data = word[i];
    end
  end
endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl
  import pp_buf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic fill_done,
  input  logic proc_busy,
  input  logic proc_en,
  output logic bank_sel,
  output logic fill_ready,
  output logic swap_accept
);
  assign swap_accept = swap_allowed(swap_req, fill_ready, proc_busy, proc_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_sel   <= 1'b0;
      fill_ready <= 1'b0;
    end else begin
      if (swap_accept) bank_sel <= ~bank_sel;
      fill_ready <= (fill_ready && !swap_accept) || fill_done;
    end
  end

  // R6: any change of the active set was preceded by a legal swap condition
  a_r6_toggle_only_when_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel != $past(bank_sel)) |-> ($past(fill_ready) && !$past(proc_busy) && !$past(proc_en)));

  // R7: an accepted swap consumes the loaded mark unless a new completion arrives
  a_r7_ready_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_accept && !fill_done) |=> !fill_ready);

  // R8: a refused request leaves the active set alone
  a_r8_hold_when_refused: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_accept |=> $stable(bank_sel));
endmodule

// File: rtl/pp_buf_mgr.sv
module pp_buf_mgr
  import pp_buf_pkg::*;
#(
  parameter int CHAN_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int N_FIELDS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_valid,
  input  logic [CHAN_W-1:0]   fill_chan,
  input  logic [1:0]          fill_field,
  input  logic [ADDR_W-1:0]   fill_addr,
  input  logic [DATA_W-1:0]   fill_data,
  input  logic                fill_done,
  input  logic                proc_en,
  input  logic                proc_we,
  input  logic [1:0]          proc_field,
  input  logic [ADDR_W-1:0]   proc_addr,
  input  logic [DATA_W-1:0]   proc_wdata,
  input  logic                proc_busy,
  input  logic                swap_req,
  output logic [DATA_W-1:0]   proc_rdata,
  output logic                bank_sel,
  output logic                fill_overrun
);
  localparam int N_BANKS = 2;
  localparam int FIELD_W = 2;

  logic fill_ready, swap_accept;
  logic fill_blocked, proc_rd;
  logic unused_chan_hi;
  logic [DATA_W-1:0] bank_rd [N_BANKS];
  logic [N_BANKS-1:0] fill_hit, proc_hit;

  assign unused_chan_hi = ^fill_chan[CHAN_W-1:1];
  assign fill_blocked   = fill_valid && fill_collides(fill_chan[0], bank_sel);
  assign proc_rd        = proc_en && !proc_we;

  pp_swap_ctrl u_swap (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .fill_done(fill_done),
    .proc_busy(proc_busy), .proc_en(proc_en), .bank_sel(bank_sel),
    .fill_ready(fill_ready), .swap_accept(swap_accept)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic              w_en;
    logic [FIELD_W-1:0] w_field;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;

    assign fill_hit[b] = fill_valid && (fill_chan[0] == 1'(b)) && (bank_sel != 1'(b));
    assign proc_hit[b] = proc_en && proc_we && (bank_sel == 1'(b));
    assign w_en    = fill_hit[b] || proc_hit[b];
    assign w_field = fill_hit[b] ? fill_field : proc_field;
    assign w_addr  = fill_hit[b] ? fill_addr  : proc_addr;
    assign w_data  = fill_hit[b] ? fill_data  : proc_wdata;

    pp_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W)) u_bank (
      .clk(clk), .wr_en(w_en), .wr_field(w_field), .wr_addr(w_addr), .wr_data(w_data),
      .rd_field(proc_field), .rd_addr(proc_addr), .rd_data(bank_rd[b])
    );

    // R2/R3: one writer per set per cycle, never both sides on the same set
    a_r3_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fill_hit[b], proc_hit[b]}));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proc_rdata   <= '0;
      fill_overrun <= 1'b0;
    end else begin
      fill_overrun <= fill_blocked;
      if (proc_rd) proc_rdata <= bank_rd[bank_sel];
    end
  end

  // R3: a fill aimed at the active set raises the flag next cycle
  a_r3_overrun_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (fill_chan[0] == bank_sel)) |=> fill_overrun);

  // R3: the flag never appears without a colliding fill before it
  a_r3_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fill_overrun |-> ($past(fill_valid) && ($past(fill_chan[0]) == $past(bank_sel))));

  // R4: read data holds between reads
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_rd |=> $stable(proc_rdata));
endmodule

// File: tb/sim_pp_buf_mgr.sv
`timescale 1ns/1ps
module sim_pp_buf_mgr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_valid = 0, fill_done = 0, proc_en = 0, proc_we = 0, proc_busy = 0, swap_req = 0;
  logic [7:0] fill_chan = 0, fill_addr = 0, proc_addr = 0;
  logic [1:0] fill_field = 0, proc_field = 0;
  logic [15:0] fill_data = 0, proc_wdata = 0;
  logic [15:0] proc_rdata;
  logic bank_sel, fill_overrun;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pp_buf_mgr u0 (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_chan(fill_chan),
    .fill_field(fill_field), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_done(fill_done), .proc_en(proc_en), .proc_we(proc_we),
    .proc_field(proc_field), .proc_addr(proc_addr), .proc_wdata(proc_wdata),
    .proc_busy(proc_busy), .swap_req(swap_req), .proc_rdata(proc_rdata),
    .bank_sel(bank_sel), .fill_overrun(fill_overrun)
  );

  // {chan, field, addr, data}: odd channels, distinct field/addr pairs
  localparam logic [33:0] VEC [8] = '{
    {8'd1,   2'd0, 8'h00, 16'h1111},
    {8'd1,   2'd1, 8'h00, 16'h2222},
    {8'd1,   2'd2, 8'h00, 16'h3333},
    {8'd3,   2'd0, 8'h01, 16'hA5A5},
    {8'd255, 2'd2, 8'hFF, 16'hFFFF},
    {8'd127, 2'd1, 8'h80, 16'h0F0F},
    {8'd5,   2'd0, 8'h7F, 16'h8001},
    {8'd9,   2'd1, 8'h33, 16'h1234}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_fill(input logic [7:0] ch, input logic [1:0] f,
                         input logic [7:0] a, input logic [15:0] d);
    fill_valid = 1; fill_chan = ch; fill_field = f; fill_addr = a; fill_data = d;
    tick();
    fill_valid = 0;
  endtask

  task automatic do_read(input logic [1:0] f, input logic [7:0] a, output logic [15:0] d);
    proc_en = 1; proc_we = 0; proc_field = f; proc_addr = a;
    tick();
    proc_en = 0;
    d = proc_rdata;
  endtask

  task automatic do_write(input logic [1:0] f, input logic [7:0] a, input logic [15:0] d);
    proc_en = 1; proc_we = 1; proc_field = f; proc_addr = a; proc_wdata = d;
    tick();
    proc_en = 0; proc_we = 0;
  endtask

  task automatic pulse_done();
    fill_done = 1; tick(); fill_done = 0;
  endtask

  task automatic pulse_swap();
    swap_req = 1; tick(); swap_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    check("R1 bank_sel reset", {15'd0, bank_sel}, 16'd0);
    check("R1 rdata reset", proc_rdata, 16'h0000);
    check("R1 overrun reset", {15'd0, fill_overrun}, 16'd0);

    // R2/R10: table fill into the odd set while even is active
    for (int i = 0; i < 8; i++) begin
      do_fill(VEC[i][33:26], VEC[i][25:24], VEC[i][23:16], VEC[i][15:0]);
      check("R2 no overrun on target fill", {15'd0, fill_overrun}, 16'd0);
    end

    // R8: swap without fill_done is refused
    pulse_swap();
    check("R8 swap refused, not loaded", {15'd0, bank_sel}, 16'd0);
    pulse_done();
    // R8: busy engine refuses
    proc_busy = 1; pulse_swap(); proc_busy = 0;
    check("R8 swap refused, busy", {15'd0, bank_sel}, 16'd0);
    // R6: legal swap
    pulse_swap();
    check("R6 swap accepted", {15'd0, bank_sel}, 16'd1);
    // R7: loaded mark consumed
    pulse_swap();
    check("R7 second swap refused", {15'd0, bank_sel}, 16'd1);

    // R2/R4/R9: read back table from now-active odd set
    for (int i = 0; i < 8; i++) begin
      do_read(VEC[i][25:24], VEC[i][23:16], rd);
      check("R2 R4 R9 readback", rd, VEC[i][15:0]);
    end

    // R3: collide with active odd set
    do_fill(8'd1, 2'd0, 8'h00, 16'hDEAD);
    check("R3 overrun pulse", {15'd0, fill_overrun}, 16'd1);
    tick();
    check("R3 overrun one cycle", {15'd0, fill_overrun}, 16'd0);
    do_read(2'd0, 8'h00, rd);
    check("R3 memory untouched", rd, 16'h1111);

    // R5: processing write then read
    do_write(2'd2, 8'h40, 16'h5A5A);
    do_read(2'd2, 8'h40, rd);
    check("R5 proc write", rd, 16'h5A5A);
    // R4: hold between reads
    held = proc_rdata;
    tick(); tick();
    check("R4 rdata holds", proc_rdata, held);
    // R9: field 3 discarded and reads zero
    do_write(2'd3, 8'h40, 16'h7777);
    do_read(2'd3, 8'h40, rd);
    check("R9 field3 reads zero", rd, 16'h0000);
    do_read(2'd2, 8'h40, rd);
    check("R9 field3 write discarded", rd, 16'h5A5A);

    // R2: even fill allowed now
    do_fill(8'd4, 2'd0, 8'h05, 16'hBEEF);
    check("R2 even fill accepted", {15'd0, fill_overrun}, 16'd0);
    pulse_done();
    // R7: swap with simultaneous fill_done keeps mark set
    swap_req = 1; fill_done = 1; tick(); swap_req = 0; fill_done = 0;
    check("R7 swap with done", {15'd0, bank_sel}, 16'd0);
    do_read(2'd0, 8'h05, rd);
    check("R2 even readback", rd, 16'hBEEF);
    pulse_swap();
    check("R7 mark kept, swap accepted", {15'd0, bank_sel}, 16'd1);
    pulse_swap();
    check("R7 mark cleared, swap refused", {15'd0, bank_sel}, 16'd1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule